// File: doc/BRIEF.md
# Wide-Register Shadowed Control Bus Multiplexer

This block sits between a narrow control-register bus and a set of registers that may be wider than one bus word. The bus carries an address, a read strobe with registered read data, and a write strobe with write data. Each register is one of three kinds: readable only, writable only, or both. Each register has its own read strobe and read data input, and its own write strobe and write data output. A register wider than the bus word spans several consecutive bus addresses, called chunks. Chunk 0 carries the least significant bits.

Per-register shadow storage makes each multi-chunk access atomic. Reading the lowest chunk strobes the register once and freezes the whole value, so the higher chunks return a consistent snapshot. Writing the lower chunks only collects bytes. The register is updated, in one strobe, when its highest chunk is written. The register layout is fixed when the block is built. Registers are packed in list order, and each start address can be rounded up to a power-of-two boundary.

Top module: `csr_shadow_mux`

## Requirements
- R1: Register kinds are encoded 0 = readable only, 1 = writable only, 2 = readable and writable. A writable-only register never raises its read strobe and reads back as zero. A readable-only register never raises its write strobe, and writes to it are dropped.
- R2: Register i of width W takes ceil(W/DATA_W) chunk addresses. Registers are placed in list order from address 0. Each register's span is rounded up to a multiple of 2^ALIGN, so every start address is aligned. A register of width 0 takes no address. Example: widths 4, 8, 16, 0, 20 with ALIGN=1 and DATA_W=8 give start addresses 0, 2, 4, (none), 6, and padding at addresses 1, 3 and 9. Register data on the flat data ports is packed from bit 0 upward in list order.
- R3: A read of chunk 0 of a readable register raises that register's read strobe in the same cycle and captures its full value. Reads of higher chunks return bytes of that capture and raise no read strobe. For example, a capture of 0x5aa5 reads as 0xa5 at chunk 0 and 0x5a at chunk 1.
- R4: Read data appears on bus_rdata in the cycle after the read strobe. Reads may be issued on back-to-back cycles. In a cycle after one with no read, bus_rdata is zero.
- R5: A write to a chunk below a register's top chunk only stores the byte and raises no write strobe. A write to the top chunk raises that register's write strobe for one cycle, in the next cycle, with the assembled value on its write data (0x55 then 0xaa gives 0xaa55).
- R6: Bits of the top chunk above the register width are dropped. A 20-bit register written with 0x55, 0xaa, 0xf3 receives 0x3aa55.
- R7: At most one register's read strobe and at most one register's write strobe are high in any cycle, and only for the addressed register.
- R8: Addresses that map to no register, including alignment padding, read as zero and leave every register and every partial write untouched.
- R9: Each register keeps its own read capture and write collection, so accesses to other registers between the chunks of a wide write do not change the assembled value.
- R10: After reset, all strobes are low, bus_rdata is zero and every register's write data is zero. A register's write data changes only in the cycle its write strobe is high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Chunk address |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, one cycle after the read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| reg_rstb | output | NREG | Per-register read strobe |
| reg_rdata | input | TOT_W | Register values, packed in list order |
| reg_wstb | output | NREG | Per-register write strobe |
| reg_wdata | output | TOT_W | Committed register values, packed in list order |

## Verification
The bench builds the block with an 8-bit bus and ALIGN=1. It uses five registers of widths 4, 8, 16, 0 and 20 with kinds readable, writable, readable, both, both. This layout puts alignment padding after the small registers and after the three-chunk register. It includes a zero-width entry that must take no address, and a 20-bit register whose top chunk carries bits that must be dropped. The register inputs change every cycle, so a high-chunk read that returned live data instead of the capture would be caught. Random mixes of reads and writes over mapped, padded and unmapped addresses interleave partial wide writes with other traffic.

// File: rtl/csr_mux_pkg.sv
// Shared constants and elaboration-time helpers for the shadowed bus multiplexer.
// Assumes the bus word width is at least one bit.
package csr_mux_pkg;

    localparam int ACC_RO = 0;
    localparam int ACC_WO = 1;
    localparam int ACC_RW = 2;

    // Number of bus chunks a register of width w needs.
    function automatic int chunks_for(input int w, input int d);
        return (w + d - 1) / d;
    endfunction

    // Address span of a register after rounding up to the alignment quantum.
    function automatic int span_for(input int w, input int d, input int align);
        int c;
        int q;
        c = chunks_for(w, d);
        q = 1 << align;
        return ((c + q - 1) / q) * q;
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
// Address decoder: maps a bus address to a one-hot register hit and the chunk
// index inside that register. Padding and unmapped addresses give no hit.
// Assumes the whole layout fits inside 2^ADDR_W addresses.
module csr_addr_decode import csr_mux_pkg::*; #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NREG   = 5,
    parameter int ALIGN  = 0,
    parameter int CW     = 2,
    parameter int REG_W [NREG] = '{4, 8, 16, 0, 20}
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   hit,
    output logic [CW-1:0]     chunk
);

    // Start address of register idx: sum of the aligned spans before it.
    function automatic int base_of(input int idx);
        int b;
        b = 0;
        for (int j = 0; j < idx; j++) begin
            b += span_for(REG_W[j], DATA_W, ALIGN);
        end
        return b;
    endfunction

    logic [ADDR_W:0] addr_ext;
    logic [CW-1:0]   ofs [NREG];

    assign addr_ext = {1'b0, addr};

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam int NCH  = chunks_for(REG_W[g], DATA_W);
        localparam int BASE = base_of(g);
        if (NCH == 0) begin : g_empty
            assign hit[g] = 1'b0;
            assign ofs[g] = '0;
        end else begin : g_range
            localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
            localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + NCH);
            // Range compare against the real chunks only, not the padding.
            assign hit[g] = (addr_ext >= LO) && (addr_ext < HI);
            assign ofs[g] = hit[g] ? CW'(addr_ext - LO) : '0;
        end
    end

    // Merge the per-register chunk offsets; at most one is non-zero.
    always_comb begin
        chunk = '0;
        for (int i = 0; i < NREG; i++) begin
            chunk = chunk | ofs[i];
        end
    end

endmodule

// File: rtl/csr_reg_slot.sv
// One register's port logic: read strobe and read capture, write collection
// and commit. Assumes W >= 1 and that sel is high only for chunks 0..NCH-1.
module csr_reg_slot import csr_mux_pkg::*; #(
    parameter int DATA_W = 8,
    parameter int W      = 16,
    parameter int ACC    = ACC_RW,
    parameter int CW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [CW-1:0]     chunk,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [W-1:0]      elem_rdata,
    output logic              elem_rstb,
    output logic              elem_wstb,
    output logic [W-1:0]      elem_wdata,
    output logic [DATA_W-1:0] rd_word
);

    localparam int NCH    = chunks_for(W, DATA_W);
    localparam int PW     = NCH * DATA_W;
    localparam bit CAN_RD = (ACC != ACC_WO);
    localparam bit CAN_WR = (ACC != ACC_RO);
    localparam logic [CW-1:0] LAST_C = CW'(NCH - 1);

    logic [PW-1:0]     live_pad;
    logic [PW-1:0]     commit_val;
    logic [DATA_W-1:0] upper_word;
    logic              rd_hit;
    logic              wr_hit;
    logic              is_first;
    logic              is_last;
    logic              unused_slot;

    assign live_pad  = PW'(elem_rdata);
    assign rd_hit    = CAN_RD && sel;
    assign wr_hit    = CAN_WR && sel && bus_wr;
    assign is_first  = (chunk == '0);
    assign is_last   = (chunk == LAST_C);
    assign elem_rstb = rd_hit && bus_rd && is_first;
    assign unused_slot = ^{commit_val, live_pad};

    if (NCH > 1) begin : g_wide
        logic [PW-DATA_W-1:0] rsh;
        logic [PW-DATA_W-1:0] wsh;

        // Capture the upper chunks of the live value when chunk 0 is read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsh <= '0;
            end else if (elem_rstb) begin
                rsh <= live_pad[PW-1:DATA_W];
            end
        end

        // Select the captured byte for a higher-chunk read.
        always_comb begin
            upper_word = '0;
            for (int k = 1; k < NCH; k++) begin
                if (chunk == CW'(k)) begin
                    upper_word = rsh[(k-1)*DATA_W +: DATA_W];
                end
            end
        end

        // Collect the bytes of every chunk below the top one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wsh <= '0;
            end else if (wr_hit && !is_last) begin
                for (int k = 0; k < NCH - 1; k++) begin
                    if (chunk == CW'(k)) begin
                        wsh[k*DATA_W +: DATA_W] <= bus_wdata;
                    end
                end
            end
        end

        assign commit_val = {bus_wdata, wsh};
    end else begin : g_narrow
        assign upper_word = '0;
        assign commit_val = bus_wdata;
    end

    // Byte offered to the read multiplexer for this register.
    always_comb begin
        if (!rd_hit) begin
            rd_word = '0;
        end else if (is_first) begin
            rd_word = live_pad[DATA_W-1:0];
        end else begin
            rd_word = upper_word;
        end
    end

    // Commit the assembled value with a one-cycle strobe on the top chunk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elem_wstb  <= 1'b0;
            elem_wdata <= '0;
        end else begin
            elem_wstb <= wr_hit && is_last;
            if (wr_hit && is_last) begin
                elem_wdata <= commit_val[W-1:0];
            end
        end
    end

endmodule

// File: rtl/csr_read_mux.sv
// Read data path: ORs the per-register bytes and registers the result.
// Assumes at most one register offers a non-zero byte in a cycle.
module csr_read_mux #(
    parameter int DATA_W = 8,
    parameter int NREG   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_rd,
    input  logic [NREG*DATA_W-1:0] words,
    output logic [DATA_W-1:0]      rdata
);

    logic [DATA_W-1:0] merged;

    // Fold all register bytes into one.
    always_comb begin
        merged = '0;
        for (int i = 0; i < NREG; i++) begin
            merged = merged | words[i*DATA_W +: DATA_W];
        end
    end

    // Present the byte one cycle after the read, zero when no read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= bus_rd ? merged : '0;
        end
    end

endmodule

// File: rtl/csr_shadow_mux.sv
// Top: connects a narrow register bus to NREG registers of build-time widths
// and kinds. Wide registers get atomic access through per-register shadows.
// Assumes the sum of the widths is at least 1.
module csr_shadow_mux import csr_mux_pkg::*; #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int NREG    = 5,
    parameter int ALIGN   = 0,
    parameter int REG_W   [NREG] = '{4, 8, 16, 0, 20},
    parameter int REG_ACC [NREG] = '{ACC_RO, ACC_WO, ACC_RW, ACC_RW, ACC_RW},
    localparam int TOT_W  = REG_W.sum()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [NREG-1:0]   reg_rstb,
    input  logic [TOT_W-1:0]  reg_rdata,
    output logic [NREG-1:0]   reg_wstb,
    output logic [TOT_W-1:0]  reg_wdata
);

    // Largest chunk count of any register.
    function automatic int max_chunks();
        int m;
        m = 1;
        for (int j = 0; j < NREG; j++) begin
            if (chunks_for(REG_W[j], DATA_W) > m) begin
                m = chunks_for(REG_W[j], DATA_W);
            end
        end
        return m;
    endfunction

    // Bit offset of register idx on the flat data ports.
    function automatic int off_of(input int idx);
        int o;
        o = 0;
        for (int j = 0; j < idx; j++) begin
            o += REG_W[j];
        end
        return o;
    endfunction

    localparam int MAX_CH = max_chunks();
    localparam int CW     = (MAX_CH > 1) ? $clog2(MAX_CH) : 1;

    logic [NREG-1:0]        hit;
    logic [CW-1:0]          chunk;
    logic [NREG*DATA_W-1:0] words;
    logic                   unused_hit;

    assign unused_hit = ^hit;

    csr_addr_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NREG   (NREG),
        .ALIGN  (ALIGN),
        .CW     (CW),
        .REG_W  (REG_W)
    ) u_decode (
        .addr  (bus_addr),
        .hit   (hit),
        .chunk (chunk)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (REG_W[g] == 0) begin : g_void
            assign reg_rstb[g] = 1'b0;
            assign reg_wstb[g] = 1'b0;
            assign words[g*DATA_W +: DATA_W] = '0;
        end else begin : g_live
            localparam int OFF = off_of(g);
            csr_reg_slot #(
                .DATA_W (DATA_W),
                .W      (REG_W[g]),
                .ACC    (REG_ACC[g]),
                .CW     (CW)
            ) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .sel        (hit[g]),
                .chunk      (chunk),
                .bus_rd     (bus_rd),
                .bus_wr     (bus_wr),
                .bus_wdata  (bus_wdata),
                .elem_rdata (reg_rdata[OFF +: REG_W[g]]),
                .elem_rstb  (reg_rstb[g]),
                .elem_wstb  (reg_wstb[g]),
                .elem_wdata (reg_wdata[OFF +: REG_W[g]]),
                .rd_word    (words[g*DATA_W +: DATA_W])
            );
        end
    end

    csr_read_mux #(
        .DATA_W (DATA_W),
        .NREG   (NREG)
    ) u_rdmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_rd (bus_rd),
        .words  (words),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/csr_shadow_mux_chk.sv
// Checker for csr_shadow_mux: strobe exclusivity, strobe causes, idle read
// data and write-data hold. Attached to every instance by the bind below.
module csr_shadow_mux_chk import csr_mux_pkg::*; #(
    parameter int DATA_W = 8,
    parameter int NREG   = 5,
    parameter int TOT_W  = 48,
    parameter int REG_ACC [NREG] = '{ACC_RO, ACC_WO, ACC_RW, ACC_RW, ACC_RW}
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NREG-1:0]   reg_rstb,
    input logic [NREG-1:0]   reg_wstb,
    input logic [TOT_W-1:0]  reg_wdata
);

    AST_RSTB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(reg_rstb)); // R7
    AST_WSTB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(reg_wstb)); // R7
    AST_RSTB_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n) (|reg_rstb) |-> bus_rd); // R3
    AST_WSTB_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n) (|reg_wstb) |-> $past(bus_wr)); // R5
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd |=> (bus_rdata == '0)); // R4
    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(|reg_wstb) |-> $stable(reg_wdata)); // R10

    for (genvar g = 0; g < NREG; g++) begin : g_kind
        if (REG_ACC[g] == ACC_RO) begin : g_ro
            AST_RO_NO_WSTB: assert property (@(posedge clk) disable iff (!rst_n) !reg_wstb[g]); // R1
        end else if (REG_ACC[g] == ACC_WO) begin : g_wo
            AST_WO_NO_RSTB: assert property (@(posedge clk) disable iff (!rst_n) !reg_rstb[g]); // R1
        end
    end

endmodule

bind csr_shadow_mux csr_shadow_mux_chk #(
    .DATA_W  (DATA_W),
    .NREG    (NREG),
    .TOT_W   (TOT_W),
    .REG_ACC (REG_ACC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .reg_rstb  (reg_rstb),
    .reg_wstb  (reg_wstb),
    .reg_wdata (reg_wdata)
);

// File: tb/csr_shadow_mux_bench.sv
// Bench: directed corner cases plus seeded random traffic, checked against a
// bench-side model built from the requirements.
module csr_shadow_mux_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NR = 5;
    localparam int AL = 1;
    localparam int BW [NR] = '{4, 8, 16, 0, 20};
    localparam int BA [NR] = '{0, 1, 0, 2, 2};
    localparam int TW = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [NR-1:0] reg_rstb;
    logic [TW-1:0] reg_rdata = '0;
    logic [NR-1:0] reg_wstb;
    logic [TW-1:0] reg_wdata;

    int vectors = 0;
    int fails = 0;

    logic [31:0] m_rsh [NR];
    logic [31:0] m_wsh [NR];
    logic [31:0] m_wdata [NR];
    logic [NR-1:0] m_wstb;
    logic [7:0]    m_rdata;
    string         prev_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_shadow_mux #(
        .ADDR_W  (AW),
        .DATA_W  (DW),
        .NREG    (NR),
        .ALIGN   (AL),
        .REG_W   (BW),
        .REG_ACC (BA)
    ) u_csr_shadow_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .reg_rstb  (reg_rstb),
        .reg_rdata (reg_rdata),
        .reg_wstb  (reg_wstb),
        .reg_wdata (reg_wdata)
    );

    function automatic int nchunks(input int w);
        return (w + DW - 1) / DW;
    endfunction

    function automatic int span(input int w);
        int q;
        q = 1 << AL;
        return ((nchunks(w) + q - 1) / q) * q;
    endfunction

    function automatic int base(input int idx);
        int b;
        b = 0;
        for (int j = 0; j < idx; j++) b += span(BW[j]);
        return b;
    endfunction

    function automatic int boff(input int idx);
        int o;
        o = 0;
        for (int j = 0; j < idx; j++) o += BW[j];
        return o;
    endfunction

    function automatic logic [31:0] wmask(input int w);
        return (w >= 32) ? 32'hffff_ffff : ((32'd1 << w) - 32'd1);
    endfunction

    // Register index for an address (-1 if none) and the chunk inside it.
    function automatic int find_reg(input int a, output int ch);
        ch = 0;
        for (int i = 0; i < NR; i++) begin
            if (BW[i] > 0 && a >= base(i) && a < base(i) + nchunks(BW[i])) begin
                ch = a - base(i);
                return i;
            end
        end
        return -1;
    endfunction

    function automatic logic [31:0] live(input int idx);
        logic [TW-1:0] s;
        s = reg_rdata >> boff(idx);
        return s[31:0] & wmask(BW[idx]);
    endfunction

    function automatic logic [TW-1:0] exp_wvec();
        logic [TW-1:0] v;
        v = '0;
        for (int i = 0; i < NR; i++) begin
            for (int b = 0; b < BW[i]; b++) v[boff(i) + b] = m_wdata[i][b];
        end
        return v;
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_live(input int idx, input logic [31:0] v);
        for (int b = 0; b < BW[idx]; b++) reg_rdata[boff(idx) + b] = v[b];
    endtask

    // One bus cycle: check last cycle's registered outputs, drive, check the
    // read strobes, then advance the model across the clock edge.
    task automatic step(input int a, input bit rd, input bit wr, input logic [7:0] wd, input string tag);
        int idx;
        int ch;
        logic [NR-1:0] erstb;
        logic [31:0]   v;
        chk(prev_tag, "bus_rdata", 64'(bus_rdata), 64'(m_rdata));
        chk(prev_tag, "reg_wstb", 64'(reg_wstb), 64'(m_wstb));
        chk(prev_tag, "reg_wdata", 64'(reg_wdata), 64'(exp_wvec()));
        bus_addr = AW'(a);
        bus_rd = rd;
        bus_wr = wr;
        bus_wdata = wd;
        #1;
        idx = find_reg(a, ch);
        erstb = '0;
        m_rdata = 8'h00;
        m_wstb = '0;
        if (idx >= 0 && rd && BA[idx] != 1) begin
            if (ch == 0) begin
                erstb[idx] = 1'b1;
                v = live(idx);
                m_rdata = v[7:0];
                m_rsh[idx] = v;
            end else begin
                v = m_rsh[idx] >> (8 * ch);
                m_rdata = v[7:0];
            end
        end
        chk(tag, "reg_rstb", 64'(reg_rstb), 64'(erstb));
        if (idx >= 0 && wr && BA[idx] != 0) begin
            if (ch < nchunks(BW[idx]) - 1) begin
                m_wsh[idx][8*ch +: 8] = wd;
            end else begin
                v = (m_wsh[idx] & ((32'd1 << (8 * ch)) - 32'd1)) | (32'(wd) << (8 * ch));
                m_wdata[idx] = v & wmask(BW[idx]);
                m_wstb[idx] = 1'b1;
            end
        end
        prev_tag = tag;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'd7321);
        for (int i = 0; i < NR; i++) begin
            m_rsh[i] = '0;
            m_wsh[i] = '0;
            m_wdata[i] = '0;
        end
        m_wstb = '0;
        m_rdata = '0;
        prev_tag = "R10";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state.
        chk("R10", "reset rdata", 64'(bus_rdata), 64'h0);
        chk("R10", "reset wstb", 64'(reg_wstb), 64'h0);
        chk("R10", "reset rstb", 64'(reg_rstb), 64'h0);
        chk("R10", "reset wdata", 64'(reg_wdata), 64'h0);

        // R3 / R4: capture 0x5aa5 at chunk 0, high chunk from capture while live changes.
        set_live(2, 32'h5aa5);
        step(4, 1, 0, 8'h00, "R3");
        chk("R3", "chunk0 byte", 64'(bus_rdata), 64'ha5);
        set_live(2, 32'h1234);
        step(5, 1, 0, 8'h00, "R4");
        chk("R4", "pipelined high byte", 64'(bus_rdata), 64'h5a);
        chk("R3", "no strobe on high chunk", 64'(reg_rstb), 64'h0);
        // R2: register 0 at address 0.
        set_live(0, 32'ha);
        step(0, 1, 0, 8'h00, "R2");
        chk("R2", "reg0 read", 64'(bus_rdata), 64'h0a);

        // R5 / R6: three-chunk write, top-chunk excess bits dropped.
        step(6, 0, 1, 8'h55, "R5");
        chk("R5", "no strobe chunk0", 64'(reg_wstb), 64'h0);
        step(7, 0, 1, 8'haa, "R5");
        chk("R5", "no strobe chunk1", 64'(reg_wstb), 64'h0);
        step(8, 0, 1, 8'hf3, "R6");
        chk("R5", "commit strobe", 64'(reg_wstb), 64'h10);
        chk("R6", "assembled value", 64'(reg_wdata[28 +: 20]), 64'h3aa55);

        // R9: traffic to other registers between chunks.
        step(6, 0, 1, 8'h11, "R9");
        step(4, 1, 0, 8'h00, "R9");
        step(7, 0, 1, 8'h22, "R9");
        step(0, 0, 1, 8'hff, "R1");
        chk("R1", "readable-only write dropped", 64'(reg_wstb), 64'h0);
        step(2, 0, 1, 8'h3c, "R2");
        chk("R2", "reg1 strobe", 64'(reg_wstb), 64'h02);
        chk("R2", "reg1 data", 64'(reg_wdata[4 +: 8]), 64'h3c);
        step(8, 0, 1, 8'h03, "R9");
        chk("R9", "assembled after interleave", 64'(reg_wdata[28 +: 20]), 64'h32211);

        // R8: padding and unmapped addresses.
        step(6, 0, 1, 8'h44, "R8");
        step(9, 0, 1, 8'h77, "R8");
        chk("R8", "padding write dropped", 64'(reg_wstb), 64'h0);
        step(1, 1, 1, 8'h99, "R8");
        chk("R8", "padding read", 64'(bus_rdata), 64'h0);
        step(200, 1, 1, 8'h66, "R8");
        chk("R8", "unmapped read", 64'(bus_rdata), 64'h0);
        step(7, 0, 1, 8'h88, "R8");
        step(8, 0, 1, 8'h0b, "R8");
        chk("R8", "partial write intact", 64'(reg_wdata[28 +: 20]), 64'hb8844);

        // R1: writable-only register reads as zero.
        set_live(1, 32'hc3);
        step(2, 1, 0, 8'h00, "R1");
        chk("R1", "writable-only read", 64'(bus_rdata), 64'h0);

        // R7: random traffic, strobes checked against the model every cycle.
        for (int n = 0; n < 4000; n++) begin
            reg_rdata = {$urandom, $urandom};
            step($urandom_range(0, 15), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 8'($urandom), "R7");
        end
        step(0, 0, 0, 8'h00, "R4");
        step(0, 0, 0, 8'h00, "R4");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        vectors++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule